// File: doc/BRIEF.md
# Interrupt and Exception Control Unit for a 32-bit RISC Core

This unit keeps the three system-control words a simple 32-bit RISC pipeline needs for trap handling: a status word (global interrupt enable, exception-level flag, interrupt mask), a cause word (sampled interrupt-pending lines and the code of the last trap) and the saved return address. At every instruction boundary that the core presents, it decides whether the instruction may run or whether control must move to the trap handler. Pending interrupts are examined before the presented instruction executes, so the saved return address is that of the instruction that did not run.

The core reports its own synchronous faults (arithmetic overflow, use of an absent coprocessor, breakpoint) as a request with a 5-bit code. The unit answers one cycle later with a one-cycle pulse and a redirect address: the fixed handler entry point for a trap, or the saved return address for a return-from-exception. Software changes the status word through a single write port.

Top module: `cp0_exc_ctrl`

## Requirements
- R1: After reset the status, cause and return-address outputs read zero, and neither pulse output is asserted.
- R2: Cause bits 15:8 show the raw interrupt lines as sampled on the previous clock edge, whatever the enables and mask hold.
- R3: At a boundary (`insn_valid_i` high) an interrupt is taken exactly when status bit 0 (enable) is 1, status bit 1 (exception level) is 0, and cause bits 15:8 ANDed with status bits 15:8 (mask) are nonzero; the trap code written is 0.
- R4: Every trap taken raises `exc_taken_o` for one cycle in the cycle after the boundary, sets status bit 1, and drives `redirect_pc_o` to 0x80000180.
- R5: A core fault request at a boundary is taken whatever the enable bit holds, and its code is written into cause bits 6:2 (overflow 12, coprocessor unusable 11, breakpoint 9).
- R6: When an interrupt is taken at a boundary that also carries a fault request or a return request, the interrupt wins: code 0 is written and the other request is dropped.
- R7: While status bit 1 is 1, no interrupt is taken; the pending lines stay visible in the cause word.
- R8: A trap taken while status bit 1 is already 1 leaves the saved return address unchanged; one taken with it clear saves the boundary's `pc_i`.
- R9: A return request at a boundary with no trap clears status bit 1, raises `eret_taken_o` for one cycle and drives `redirect_pc_o` to the saved return address; enable and mask are kept. A fault request at the same boundary wins over the return.
- R10: A status write loads only bit 0, bit 1 and bits 15:8 from `st_wdata_i`; all other status bits read 0. A trap taken in the same cycle still leaves bit 1 set.
- R11: Fault and return requests presented while `insn_valid_i` is low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| insn_valid_i | input | 1 | An instruction boundary is presented this cycle |
| pc_i | input | 32 | Address of the instruction at the boundary |
| exc_req_i | input | 1 | Core fault request for the instruction at the boundary |
| exc_code_i | input | 5 | Code of the core fault |
| eret_i | input | 1 | The instruction at the boundary is a return-from-exception |
| irq_raw_i | input | 8 | Raw interrupt-pending lines |
| st_wr_i | input | 1 | Write strobe for the status word |
| st_wdata_i | input | 32 | Data for the status word |
| exc_taken_o | output | 1 | One-cycle pulse: a trap was taken at the previous boundary |
| eret_taken_o | output | 1 | One-cycle pulse: a return was taken at the previous boundary |
| redirect_pc_o | output | 32 | Fetch address to use when either pulse is high |
| status_o | output | 32 | Status word |
| cause_o | output | 32 | Cause word |
| epc_o | output | 32 | Saved return address |

## Verification
A stuck or wrongly set exception-level flag shows at the ports within one boundary: either an interrupt pulse appears while the handler should be protected, or a return fails to reopen interrupts and the next enabled boundary produces no pulse. A corrupted saved address appears in `epc_o` on the next cycle and in `redirect_pc_o` at the following return, so the bench drives nested traps and returns back to back and compares every output word after every edge against a model built from the requirements. Priority mistakes are exposed by boundaries that carry an interrupt, a fault and a return at once.

// File: rtl/cp0_pkg.sv
package cp0_pkg;

    // Trap codes written into the cause word
    localparam logic [4:0] CODE_IRQ  = 5'd0;
    localparam logic [4:0] CODE_BRK  = 5'd9;
    localparam logic [4:0] CODE_NOCP = 5'd11;
    localparam logic [4:0] CODE_OVF  = 5'd12;

    // Outcome of one instruction boundary
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_IRQ  = 2'd1,
        EV_FLT  = 2'd2,
        EV_RET  = 2'd3
    } cp0_event_e;

endpackage

// File: rtl/cp0_irq_gate.sv
module cp0_irq_gate #(
    parameter int IRQ_W = 8
) (
    input  logic             ie_i,
    input  logic             exl_i,
    input  logic [IRQ_W-1:0] ip_i,
    input  logic [IRQ_W-1:0] im_i,
    output logic             irq_ok_o
);
    logic [IRQ_W-1:0] hit;

    // One gate per interrupt line
    for (genvar g = 0; g < IRQ_W; g++) begin : g_line
        assign hit[g] = ip_i[g] & im_i[g];
    end

    assign irq_ok_o = ie_i & ~exl_i & (|hit);
endmodule

// File: rtl/cp0_event_sel.sv
module cp0_event_sel
    import cp0_pkg::*;
(
    input  logic       valid_i,
    input  logic       irq_ok_i,
    input  logic       flt_i,
    input  logic       ret_i,
    output cp0_event_e ev_o
);
    // Priority: interrupt, then core fault, then return
    always_comb begin
        ev_o = EV_NONE;
        if (valid_i) begin
            if (irq_ok_i)      ev_o = EV_IRQ;
            else if (flt_i)    ev_o = EV_FLT;
            else if (ret_i)    ev_o = EV_RET;
        end
    end
endmodule

// File: rtl/cp0_exc_ctrl.sv
module cp0_exc_ctrl
    import cp0_pkg::*;
#(
    parameter int               XLEN     = 32,
    parameter int               IRQ_W    = 8,
    parameter int               CODE_W   = 5,
    parameter logic [XLEN-1:0]  VEC_ADDR = 32'h8000_0180
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              insn_valid_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              exc_req_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              eret_i,
    input  logic [IRQ_W-1:0]  irq_raw_i,
    input  logic              st_wr_i,
    input  logic [XLEN-1:0]   st_wdata_i,
    output logic              exc_taken_o,
    output logic              eret_taken_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic [XLEN-1:0]   status_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   epc_o
);
    // Field positions inside the status and cause words
    localparam int ST_IE   = 0;
    localparam int ST_EXL  = 1;
    localparam int ST_IM   = 8;
    localparam int CA_CODE = 2;
    localparam int CA_IP   = 8;

    typedef struct packed {
        logic              ie;
        logic              exl;
        logic [IRQ_W-1:0]  im;
        logic [IRQ_W-1:0]  ip;
        logic [CODE_W-1:0] code;
        logic [XLEN-1:0]   epc;
        logic              taken;
        logic              ret;
        logic [XLEN-1:0]   rpc;
    } cp0_state_t;

    cp0_state_t st_d, st_q;
    logic       irq_ok;
    cp0_event_e ev;

    cp0_irq_gate #(.IRQ_W(IRQ_W)) u_gate (
        .ie_i     (st_q.ie),
        .exl_i    (st_q.exl),
        .ip_i     (st_q.ip),
        .im_i     (st_q.im),
        .irq_ok_o (irq_ok)
    );

    cp0_event_sel u_sel (
        .valid_i  (insn_valid_i),
        .irq_ok_i (irq_ok),
        .flt_i    (exc_req_i),
        .ret_i    (eret_i),
        .ev_o     (ev)
    );

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        st_d.ret   = 1'b0;
        st_d.ip    = irq_raw_i;
        if (st_wr_i) begin
            st_d.ie  = st_wdata_i[ST_IE];
            st_d.exl = st_wdata_i[ST_EXL];
            st_d.im  = st_wdata_i[ST_IM +: IRQ_W];
        end
        unique case (ev)
            EV_IRQ, EV_FLT: begin
                st_d.exl   = 1'b1;
                st_d.taken = 1'b1;
                st_d.rpc   = VEC_ADDR;
                st_d.code  = (ev == EV_IRQ) ? CODE_W'(CODE_IRQ) : exc_code_i;
                if (!st_q.exl) begin
                    st_d.epc = pc_i;
                end
            end
            EV_RET: begin
                st_d.exl = 1'b0;
                st_d.ret = 1'b1;
                st_d.rpc = st_q.epc;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_o                    = '0;
        status_o[ST_IE]             = st_q.ie;
        status_o[ST_EXL]            = st_q.exl;
        status_o[ST_IM +: IRQ_W]    = st_q.im;
        cause_o                     = '0;
        cause_o[CA_IP +: IRQ_W]     = st_q.ip;
        cause_o[CA_CODE +: CODE_W]  = st_q.code;
    end

    assign epc_o         = st_q.epc;
    assign exc_taken_o   = st_q.taken;
    assign eret_taken_o  = st_q.ret;
    assign redirect_pc_o = st_q.rpc;
endmodule

// File: rtl/cp0_exc_ctrl_chk.sv
module cp0_exc_ctrl_chk #(
    parameter int               XLEN     = 32,
    parameter int               IRQ_W    = 8,
    parameter int               CODE_W   = 5,
    parameter logic [XLEN-1:0]  VEC_ADDR = 32'h8000_0180
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              insn_valid_i,
    input logic [XLEN-1:0]   pc_i,
    input logic              exc_req_i,
    input logic [CODE_W-1:0] exc_code_i,
    input logic              eret_i,
    input logic [IRQ_W-1:0]  irq_raw_i,
    input logic              st_wr_i,
    input logic [XLEN-1:0]   st_wdata_i,
    input logic              exc_taken_o,
    input logic              eret_taken_o,
    input logic [XLEN-1:0]   redirect_pc_o,
    input logic [XLEN-1:0]   status_o,
    input logic [XLEN-1:0]   cause_o,
    input logic [XLEN-1:0]   epc_o
);
    logic past_ok;
    always_ff @(posedge clk_i) begin
        if (!rst_ni) past_ok <= 1'b0;
        else         past_ok <= 1'b1;
    end

    AST_TRAP_SETS_EXL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_taken_o |-> (status_o[1] && redirect_pc_o == VEC_ADDR)); // R4

    AST_IP_FOLLOWS_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok |-> cause_o[8 +: IRQ_W] == $past(irq_raw_i)); // R2

    AST_NO_IRQ_IN_HANDLER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insn_valid_i && status_o[1] && !exc_req_i) |=> !exc_taken_o); // R7

    AST_EPC_HELD_IN_HANDLER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[1]) |=> $stable(epc_o)); // R8

    AST_RET_REOPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eret_taken_o |-> (!status_o[1] && !exc_taken_o && redirect_pc_o == $past(epc_o))); // R9

    AST_IDLE_NO_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !insn_valid_i |=> (!exc_taken_o && !eret_taken_o)); // R11

    AST_FAULT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insn_valid_i && exc_req_i && !status_o[1] && !status_o[0])
            |=> (exc_taken_o && cause_o[2 +: CODE_W] == $past(exc_code_i)
                 && epc_o == $past(pc_i))); // R5

    AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_wr_i && !insn_valid_i && !eret_i)
            |=> (status_o[0] == $past(st_wdata_i[0])
                 && status_o[8 +: IRQ_W] == $past(st_wdata_i[8 +: IRQ_W]))); // R10

    always_comb begin
        if (rst_ni) begin
            AST_RESERVED_ZERO: assert (status_o[XLEN-1:8+IRQ_W] == '0
                && status_o[7:2] == '0 && cause_o[7] == 1'b0
                && cause_o[1:0] == 2'b00); // R10
        end
    end
endmodule

bind cp0_exc_ctrl cp0_exc_ctrl_chk #(
    .XLEN(XLEN), .IRQ_W(IRQ_W), .CODE_W(CODE_W), .VEC_ADDR(VEC_ADDR)
) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .insn_valid_i(insn_valid_i), .pc_i(pc_i),
    .exc_req_i(exc_req_i), .exc_code_i(exc_code_i), .eret_i(eret_i),
    .irq_raw_i(irq_raw_i), .st_wr_i(st_wr_i), .st_wdata_i(st_wdata_i),
    .exc_taken_o(exc_taken_o), .eret_taken_o(eret_taken_o),
    .redirect_pc_o(redirect_pc_o), .status_o(status_o), .cause_o(cause_o),
    .epc_o(epc_o)
);

// File: tb/cp0_exc_ctrl_tb_top.sv
module cp0_exc_ctrl_tb_top;
    localparam logic [31:0] VEC = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] pc = '0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        eret = 1'b0;
    logic [7:0]  irq_raw = '0;
    logic        st_wr = 1'b0;
    logic [31:0] st_wdata = '0;
    logic        exc_taken, eret_taken;
    logic [31:0] redirect_pc, status, cause, epc;

    always #10 clk = ~clk; // 50 MHz

    cp0_exc_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .insn_valid_i(insn_valid), .pc_i(pc),
        .exc_req_i(exc_req), .exc_code_i(exc_code), .eret_i(eret),
        .irq_raw_i(irq_raw), .st_wr_i(st_wr), .st_wdata_i(st_wdata),
        .exc_taken_o(exc_taken), .eret_taken_o(eret_taken),
        .redirect_pc_o(redirect_pc), .status_o(status), .cause_o(cause),
        .epc_o(epc)
    );

    typedef struct {
        string       tag;
        logic        taken;
        logic        ret;
        logic [31:0] rpc;
        logic [31:0] st;
        logic [31:0] ca;
        logic [31:0] ep;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // Reference state built from the requirements
    bit        m_ie, m_exl;
    bit [7:0]  m_im, m_ip;
    bit [4:0]  m_code;
    bit [31:0] m_epc;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic step(input string tag, input bit v, input logic [31:0] a,
                        input bit fl, input logic [4:0] cd, input bit rt,
                        input logic [7:0] lines, input bit wr, input logic [31:0] wd);
        exp_t e;
        bit   irq_go, flt_go, ret_go;
        @(negedge clk);
        insn_valid = v; pc = a; exc_req = fl; exc_code = cd; eret = rt;
        irq_raw = lines; st_wr = wr; st_wdata = wd;
        irq_go = v && m_ie && !m_exl && ((m_ip & m_im) != 0);
        flt_go = v && !irq_go && fl;
        ret_go = v && !irq_go && !fl && rt;
        e.tag = tag; e.taken = irq_go || flt_go; e.ret = ret_go; e.rpc = '0;
        if (wr) begin m_ie = wd[0]; m_exl = wd[1]; m_im = wd[15:8]; end
        if (irq_go || flt_go) begin
            e.rpc  = VEC;
            m_code = irq_go ? 5'd0 : cd;
            if (!m_exl_before(irq_go, flt_go)) m_epc = a;
            m_exl  = 1'b1;
        end else if (ret_go) begin
            e.rpc = m_epc;
            m_exl = 1'b0;
        end
        m_ip = lines;
        e.st = {16'h0, m_im, 6'h0, m_exl, m_ie};
        e.ca = {16'h0, m_ip, 1'b0, m_code, 2'b00};
        e.ep = m_epc;
        q.push_back(e);
        prev_exl = m_exl;
    endtask

    // Exception level as seen at the boundary (before this cycle's update)
    bit prev_exl = 1'b0;
    function automatic bit m_exl_before(input bit a, input bit b);
        return (a || b) ? prev_exl : prev_exl;
    endfunction

    // Monitor: compares each cycle's outputs after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                logic [31:0] arpc;
                e = q.pop_front();
                arpc = (exc_taken || eret_taken) ? redirect_pc : '0;
                checks++;
                if (exc_taken !== e.taken || eret_taken !== e.ret || arpc !== e.rpc ||
                    status !== e.st || cause !== e.ca || epc !== e.ep) begin
                    errors++;
                    $display("FAIL %s: got trap=%0b ret=%0b rpc=%h st=%h ca=%h epc=%h exp trap=%0b ret=%0b rpc=%h st=%h ca=%h epc=%h",
                             e.tag, exc_taken, eret_taken, arpc, status, cause, epc,
                             e.taken, e.ret, e.rpc, e.st, e.ca, e.ep);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got no completion, exp completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++; // R1 reset state
        if (status !== 0 || cause !== 0 || epc !== 0 || exc_taken !== 0 || eret_taken !== 0) begin
            errors++;
            $display("FAIL R1: got st=%h ca=%h epc=%h trap=%0b ret=%0b exp all zero",
                     status, cause, epc, exc_taken, eret_taken);
        end
        rst_n = 1'b1;

        // R2: lines visible in cause with everything disabled
        step("R2",  0, 32'h0,   0, 5'd0,  0, 8'h05, 0, 32'h0);
        // R3: boundary with enable clear takes nothing
        step("R3",  1, 32'h100, 0, 5'd0,  0, 8'h05, 0, 32'h0);
        // R10: write with junk in reserved bits; only enable, level, mask kept
        step("R10", 0, 32'h0,   0, 5'd0,  0, 8'h05, 1, 32'hFFFF_02FD);
        // R3: pending 0x05 masked by 0x02 -> no interrupt
        step("R3",  1, 32'h104, 0, 5'd0,  0, 8'h06, 0, 32'h0);
        // R6 + R4: line 1 now pending and enabled; fault request dropped, code 0
        step("R6",  1, 32'h108, 1, 5'd12, 1, 8'h06, 0, 32'h0);
        // R7: in handler, interrupt still pending, not taken
        step("R7",  1, 32'h180, 0, 5'd0,  0, 8'h06, 0, 32'h0);
        // R8: nested breakpoint keeps saved address 0x108; lines drop
        step("R8",  1, 32'h184, 1, 5'd9,  0, 8'h00, 0, 32'h0);
        // R9: return to 0x108, level cleared, enable and mask kept
        step("R9",  1, 32'h188, 0, 5'd0,  1, 8'h00, 0, 32'h0);
        // R5: coprocessor-unusable fault saves its own address
        step("R5",  1, 32'h200, 1, 5'd11, 0, 8'h00, 0, 32'h0);
        // R11: requests without a boundary are ignored
        step("R11", 0, 32'h204, 1, 5'd12, 1, 8'h00, 0, 32'h0);
        // R9: fault beats return at the same boundary (nested, epc kept)
        step("R9",  1, 32'h208, 1, 5'd9,  1, 8'h00, 0, 32'h0);
        step("R9",  1, 32'h20C, 0, 5'd0,  1, 8'h00, 0, 32'h0);
        // R5: overflow fault with enable set but nothing pending
        step("R5",  1, 32'h300, 1, 5'd12, 0, 8'h00, 0, 32'h0);
        step("R9",  1, 32'h304, 0, 5'd0,  1, 8'h00, 0, 32'h0);
        // R10: write clearing level plus fault in the same cycle -> level stays set
        step("R10", 1, 32'h400, 1, 5'd9,  0, 8'h00, 1, 32'h0000_0101);
        step("R9",  1, 32'h404, 0, 5'd0,  1, 8'h01, 0, 32'h0);
        // R3: line 0 pending, mask 0x01, enable set -> interrupt
        step("R3",  1, 32'h500, 0, 5'd0,  0, 8'h01, 0, 32'h0);
        // R6: interrupt beats a return request when level is clear
        step("R9",  1, 32'h180, 0, 5'd0,  1, 8'h01, 0, 32'h0);
        step("R6",  1, 32'h600, 0, 5'd0,  1, 8'h00, 0, 32'h0);
        step("R11", 0, 32'h0,   0, 5'd0,  0, 8'h00, 0, 32'h0);

        @(negedge clk);
        insn_valid = 0; exc_req = 0; eret = 0; st_wr = 0;
        while (q.size() > 0) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule